// File: doc/BRIEF.md
# SD Data Line Timeout Watchdog

This block guards the data lines of an SD host against a card that stops answering. While a data transfer is in progress it counts SD card clock periods, signalled by a one-cycle enable strobe in the system clock domain. A data event, such as a block arriving or the card releasing busy, or the end of the transfer, returns the count to zero. If the count instead reaches the programmed limit, the block sets a sticky data-timeout error flag. The flag can also raise an interrupt request.

The limit is not a cycle count. It is chosen by a 4-bit exponent code N, and the window is 2^(N+BASE_EXP) SD clock periods, with BASE_EXP = 13 by default. Software writes the code through a control strobe and can read it back. Codes run from 0 to 14, and any larger code is stored as 14. After reset the code is 14, the longest window, so the slow card identification phase cannot time out early. Software clears the error flag by writing a 1 to the flag's bit position in the status write word. An all-ones write therefore clears it too.

Top module: `sd_data_timeout`

## Requirements
- R1: After a synchronous reset, `code_rb` reads 14, `to_flag` is 0 and `irq` is 0.
- R2: With code N stored and `data_active` high, `to_flag` rises on the clock edge that samples the 2^(N+BASE_EXP)-th `sdclk_en` strobe since counting began, and not before.
- R3: The count advances only on cycles where `sdclk_en` is high. Cycles without the strobe leave the count unchanged.
- R4: A cycle with `data_event` high returns the count to zero and does not set `to_flag`.
- R5: A cycle with `data_active` low returns the count to zero and does not set `to_flag`.
- R6: A write of code 15 is stored as 14. It reads back as 14 and gives the 2^(14+BASE_EXP) window.
- R7: `to_flag` stays set until a cycle with `stat_wr` high and `stat_wdata[FLAG_BIT]` = 1, where FLAG_BIT defaults to 20. A status write with that bit at 0 has no effect. An all-ones write clears the flag.
- R8: `irq` is high exactly when `to_flag` is high and `irq_en` is high.
- R9: If an expiry and a clearing status write fall on the same edge, the flag ends up set.
- R10: A write of any code from 0 to 14 is stored unchanged and appears on `code_rb` after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sdclk_en | input | 1 | One-cycle strobe per SD card clock period |
| data_active | input | 1 | High while a data transfer is in progress |
| data_event | input | 1 | Restart pulse on a data or busy-release event |
| ctrl_wr | input | 1 | Write strobe for the timeout code |
| ctrl_code | input | 4 | Timeout exponent code written on `ctrl_wr` |
| stat_wr | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | STAT_W | Status write data; bit FLAG_BIT clears the flag |
| irq_en | input | 1 | Signal enable for the interrupt request |
| code_rb | output | 4 | Stored timeout code |
| to_flag | output | 1 | Sticky data-timeout error flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `sdclk_en`, `data_event` and the write strobes are synchronous to `clk` and settle before each edge. They also assume that reset is held for at least one edge before any property is evaluated. The bench drives every input on the falling edge, holds reset for several cycles, and raises data events only as single-cycle pulses. It builds the timing checks with a reduced BASE_EXP, so that the longest window, reached through a code of 15, fits in the run.

// File: rtl/sd_to_pkg.sv
package sd_to_pkg;
    localparam int CODE_W   = 4;
    localparam int MAX_CODE = 14;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/sd_to_code_reg.sv
module sd_to_code_reg
    import sd_to_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  code_t wcode,
    output code_t code
);
    typedef struct packed {
        code_t code;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (int'(wcode) > MAX_CODE) st_d.code = code_t'(MAX_CODE);
            else                        st_d.code = wcode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.code <= code_t'(MAX_CODE);
        else     st_q <= st_d;
    end

    assign code = st_q.code;
endmodule

// File: rtl/sd_to_counter.sv
module sd_to_counter
    import sd_to_pkg::*;
#(
    parameter int BASE_EXP = 13
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  active,
    input  logic  restart,
    input  code_t code,
    output logic  expire
);
    localparam int CW = BASE_EXP + MAX_CODE + 2;

    typedef struct packed {
        logic [CW-1:0] count;
    } state_t;

    state_t        st_d, st_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] count_inc;

    always_comb begin
        st_d      = st_q;
        limit     = CW'(1) << (BASE_EXP + int'(code));
        count_inc = st_q.count + CW'(1);
        expire    = active && !restart && tick && (count_inc >= limit);
        if (!active || restart) begin
            st_d.count = '0;
        end else if (tick) begin
            st_d.count = expire ? '0 : count_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.count <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/sd_to_status.sv
module sd_to_status #(
    parameter int STAT_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_evt,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              sig_en,
    output logic              flag,
    output logic              req
);
    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && wdata[FLAG_BIT]) st_d.flag = 1'b0;
        if (set_evt)               st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.flag <= 1'b0;
        else     st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign req  = st_q.flag & sig_en;
endmodule

// File: rtl/sd_data_timeout.sv
module sd_data_timeout #(
    parameter int BASE_EXP = 13,
    parameter int STAT_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdclk_en,
    input  logic              data_active,
    input  logic              data_event,
    input  logic              ctrl_wr,
    input  logic [3:0]        ctrl_code,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              irq_en,
    output logic [3:0]        code_rb,
    output logic              to_flag,
    output logic              irq
);
    import sd_to_pkg::*;

    code_t code;
    logic  expire;

    sd_to_code_reg u_code (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctrl_wr),
        .wcode (ctrl_code),
        .code  (code)
    );

    sd_to_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (sdclk_en),
        .active  (data_active),
        .restart (data_event),
        .code    (code),
        .expire  (expire)
    );

    sd_to_status #(.STAT_W(STAT_W), .FLAG_BIT(FLAG_BIT)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_evt (expire),
        .wr      (stat_wr),
        .wdata   (stat_wdata),
        .sig_en  (irq_en),
        .flag    (to_flag),
        .req     (irq)
    );

    assign code_rb = code;
endmodule

// File: rtl/sd_data_timeout_chk.sv
module sd_data_timeout_chk #(
    parameter int STAT_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              sdclk_en,
    input logic              data_active,
    input logic              data_event,
    input logic              stat_wr,
    input logic [STAT_W-1:0] stat_wdata,
    input logic              irq_en,
    input logic [3:0]        code_rb,
    input logic              to_flag,
    input logic              irq
);
    assert_reset_code_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_rb == 4'd14 && !to_flag));

    assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
        code_rb <= 4'd14);

    assert_rise_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(to_flag) |-> $past(sdclk_en && data_active && !data_event));

    assert_event_no_set_R4: assert property (@(posedge clk) disable iff (rst)
        (data_event && !to_flag) |=> !to_flag);

    assert_idle_no_set_R5: assert property (@(posedge clk) disable iff (rst)
        (!data_active && !to_flag) |=> !to_flag);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (to_flag && !(stat_wr && stat_wdata[FLAG_BIT])) |=> to_flag);

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_wdata[FLAG_BIT] && !data_active) |=> !to_flag);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (to_flag && irq_en));
endmodule

bind sd_data_timeout sd_data_timeout_chk #(.STAT_W(STAT_W), .FLAG_BIT(FLAG_BIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sdclk_en    (sdclk_en),
    .data_active (data_active),
    .data_event  (data_event),
    .stat_wr     (stat_wr),
    .stat_wdata  (stat_wdata),
    .irq_en      (irq_en),
    .code_rb     (code_rb),
    .to_flag     (to_flag),
    .irq         (irq)
);

// File: tb/tb_sd_data_timeout.sv
`timescale 1ns/1ps
module tb_sd_data_timeout;
    localparam int BASE_EXP = 2;
    localparam int STAT_W   = 32;
    localparam int FLAG_BIT = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sdclk_en = 1'b0;
    logic              data_active = 1'b0;
    logic              data_event = 1'b0;
    logic              ctrl_wr = 1'b0;
    logic [3:0]        ctrl_code = '0;
    logic              stat_wr = 1'b0;
    logic [STAT_W-1:0] stat_wdata = '0;
    logic              irq_en = 1'b0;
    logic [3:0]        code_rb;
    logic              to_flag;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sd_data_timeout #(.BASE_EXP(BASE_EXP), .STAT_W(STAT_W), .FLAG_BIT(FLAG_BIT)) dut (
        .clk(clk), .rst(rst), .sdclk_en(sdclk_en), .data_active(data_active),
        .data_event(data_event), .ctrl_wr(ctrl_wr), .ctrl_code(ctrl_code),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
        .code_rb(code_rb), .to_flag(to_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_code(input logic [3:0] c);
        ctrl_wr = 1'b1; ctrl_code = c; step(1); ctrl_wr = 1'b0;
    endtask

    task automatic stat_write(input logic [STAT_W-1:0] w);
        stat_wr = 1'b1; stat_wdata = w; step(1); stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic clear_all();
        data_active = 1'b0; sdclk_en = 1'b0;
        stat_write('1);
    endtask

    task automatic t_reset();
        rst = 1'b1; step(4); rst = 1'b0; step(1);
        chk(code_rb == 4'd14, "R1 code", code_rb, 14);
        chk(to_flag == 1'b0, "R1 flag", to_flag, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_period(input logic [3:0] c);
        int lim = 1 << (BASE_EXP + c);
        set_code(c);
        chk(code_rb == c, "R10 readback", code_rb, c);
        sdclk_en = 1'b1; data_active = 1'b1;
        step(lim - 1);
        chk(to_flag == 1'b0, "R2 before limit", to_flag, 0);
        step(1);
        chk(to_flag == 1'b1, "R2 at limit", to_flag, 1);
        clear_all();
        chk(to_flag == 1'b0, "R7 all ones clear", to_flag, 0);
    endtask

    task automatic t_gating();
        set_code(4'd0);
        data_active = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sdclk_en = 1'b1; step(1); sdclk_en = 1'b0; step(2);
        end
        step(5);
        chk(to_flag == 1'b0, "R3 no strobe no count", to_flag, 0);
        sdclk_en = 1'b1; step(1); sdclk_en = 1'b0;
        chk(to_flag == 1'b1, "R3 fourth strobe", to_flag, 1);
        clear_all();
    endtask

    task automatic t_event();
        set_code(4'd0);
        sdclk_en = 1'b1; data_active = 1'b1;
        step(3);
        data_event = 1'b1; step(1); data_event = 1'b0;
        chk(to_flag == 1'b0, "R4 event no flag", to_flag, 0);
        step(3);
        chk(to_flag == 1'b0, "R4 restarted count", to_flag, 0);
        step(1);
        chk(to_flag == 1'b1, "R4 full window after event", to_flag, 1);
        clear_all();
    endtask

    task automatic t_inactive();
        set_code(4'd0);
        sdclk_en = 1'b1; data_active = 1'b1;
        step(3);
        data_active = 1'b0; step(1); data_active = 1'b1;
        chk(to_flag == 1'b0, "R5 idle no flag", to_flag, 0);
        step(3);
        chk(to_flag == 1'b0, "R5 restarted count", to_flag, 0);
        step(1);
        chk(to_flag == 1'b1, "R5 full window after idle", to_flag, 1);
        data_active = 1'b0; sdclk_en = 1'b0;
    endtask

    task automatic t_sticky_irq();
        logic [STAT_W-1:0] other;
        step(10);
        chk(to_flag == 1'b1, "R7 sticky", to_flag, 1);
        irq_en = 1'b0; #1;
        chk(irq == 1'b0, "R8 masked", irq, 0);
        irq_en = 1'b1; #1;
        chk(irq == 1'b1, "R8 enabled", irq, 1);
        @(negedge clk);
        other = '1; other[FLAG_BIT] = 1'b0;
        stat_write(other);
        chk(to_flag == 1'b1, "R7 other bits ignored", to_flag, 1);
        chk(irq == 1'b1, "R8 still requesting", irq, 1);
        other = '0; other[FLAG_BIT] = 1'b1;
        stat_write(other);
        chk(to_flag == 1'b0, "R7 single bit clear", to_flag, 0);
        chk(irq == 1'b0, "R8 drops with flag", irq, 0);
        irq_en = 1'b0;
    endtask

    task automatic t_set_wins();
        set_code(4'd0);
        sdclk_en = 1'b1; data_active = 1'b1;
        step(3);
        stat_wr = 1'b1; stat_wdata = '1; step(1); stat_wr = 1'b0; stat_wdata = '0;
        chk(to_flag == 1'b1, "R9 set beats clear", to_flag, 1);
        clear_all();
    endtask

    task automatic t_saturate();
        int lim = 1 << (BASE_EXP + 14);
        set_code(4'd15);
        chk(code_rb == 4'd14, "R6 readback", code_rb, 14);
        sdclk_en = 1'b1; data_active = 1'b1;
        step(lim - 1);
        chk(to_flag == 1'b0, "R6 before max window", to_flag, 0);
        step(1);
        chk(to_flag == 1'b1, "R6 at max window", to_flag, 1);
        clear_all();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_period(4'd0);
                t_period(4'd3);
                t_gating();
                t_event();
                t_inactive();
                t_sticky_irq();
                t_set_wins();
                t_saturate();
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule